// File: doc/BRIEF.md
# Receive Repeated-Character Detector

This block sits beside the receive path between a serial controller and its receive FIFO. It sees each byte that enters the FIFO. It counts how many bytes in a row equal a programmed character. When that run reaches a programmed length, it sets a sticky "pattern seen" flag and raises a one-cycle interrupt request. A byte that differs from the programmed character breaks the run. Software uses the flag to find the end of a block in byte-synchronous traffic. For example, it can wait for several copies of an end-of-text character.

The character and the run length are each eight-bit values. A run length of zero acts as a length of one. The detector works only while its enable input is high. Dropping the enable, or resetting the receive FIFO, discards any partial run. After each detection the run count starts again from zero, so the next detection needs a full new run. The host clears the sticky flag through a dedicated clear strobe, which is normally tied to a read of the interrupt status.

Top module: `rcd_detector`

## Requirements
- R1: After reset, `pattern_seen` and `pattern_irq` are 0 and the run count is zero.
- R2: While `detect_en` is 1, each accepted byte (`rx_vld`=1) that equals `match_char` extends the run by one. The accepted byte that brings the run to `repeat_count` sets `pattern_seen` on the clock edge that accepts it.
- R3: An accepted byte that differs from `match_char` sets the run to zero, so a detection then needs `repeat_count` fresh matching bytes.
- R4: A `repeat_count` of 0 behaves exactly like a count of 1: every accepted matching byte is a detection.
- R5: `pattern_seen` stays 1 until a cycle with `status_clr`=1, after which it reads 0. If a detection happens in the same cycle as the clear, the detection wins and the flag stays 1.
- R6: A detection returns the run to zero. The byte that caused the detection does not count toward the next run.
- R7: While `detect_en` is 0, accepted bytes are ignored and the run is held at zero, so no detection can occur and a partial run is lost.
- R8: A cycle with `rx_flush`=1 sets the run to zero. Any byte offered in that same cycle is ignored.
- R9: `pattern_irq` is 1 for exactly the one cycle after each detecting edge, in which `pattern_seen` is also 1. It stays 0 in every other cycle.
- R10: Cycles with `rx_vld`=0 leave the run unchanged, whatever `rx_byte` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | A byte is moving from the serial controller into the receive FIFO this cycle |
| rx_byte | input | DATA_W (8) | The byte being transferred |
| match_char | input | DATA_W (8) | Character whose repeats are counted |
| repeat_count | input | CNT_W (8) | Run length required for a detection; 0 acts as 1 |
| detect_en | input | 1 | Detection enable; 0 holds the run at zero |
| rx_flush | input | 1 | Receive FIFO reset; clears the run |
| status_clr | input | 1 | Clears the sticky flag (host status read) |
| pattern_seen | output | 1 | Sticky detection flag |
| pattern_irq | output | 1 | One-cycle interrupt request per detection |

## Verification
On every cycle, the bound checker confirms several local rules. The run never jumps by more than one. It goes to zero after a mismatch, a flush, a disabled cycle or a detection. Idle cycles hold the run. The flag stays set until a clear arrives. Each interrupt pulse coincides with a set flag and follows an accepted matching byte. Some behaviour only the bench can show: that the detection comes on exactly the Nth matching byte for each programmed count, including zero, for several characters, and that partial runs lost to a flush or disable really cost a full new run.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    // Classification of one clock cycle as seen by the run counter.
    typedef enum logic [1:0] {
        EV_HOLD    = 2'd0,  // no byte offered: keep the run
        EV_CLEAR   = 2'd1,  // mismatch, flush or disabled: run to zero
        EV_ADVANCE = 2'd2,  // matching byte below the target length
        EV_HIT     = 2'd3   // matching byte that completes the run
    } rcd_event_e;

endpackage

// File: rtl/rcd_match.sv
module rcd_match
    import rcd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              rx_vld,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] match_char,
    input  logic [CNT_W-1:0]  repeat_count,
    input  logic              detect_en,
    input  logic              rx_flush,
    input  logic [CNT_W-1:0]  run_q,
    output rcd_event_e        ev,
    output logic [CNT_W-1:0]  run_next
);

    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] target;
    logic [EXT_W-1:0] run_plus;
    logic             same;

    always_comb begin
        // A programmed length of zero is promoted to one.
        target   = (repeat_count == '0) ? EXT_W'(1) : {1'b0, repeat_count};
        run_plus = {1'b0, run_q} + EXT_W'(1);
        same     = (rx_byte == match_char);
        run_next = run_plus[CNT_W-1:0];

        if (rx_flush || !detect_en) begin
            ev = EV_CLEAR;
        end else if (!rx_vld) begin
            ev = EV_HOLD;
        end else if (!same) begin
            ev = EV_CLEAR;
        end else if (run_plus >= target) begin
            ev = EV_HIT;
        end else begin
            ev = EV_ADVANCE;
        end
    end

endmodule

// File: rtl/rcd_run_ctr.sv
module rcd_run_ctr
    import rcd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rcd_event_e       ev,
    input  logic [CNT_W-1:0] run_next,
    output logic [CNT_W-1:0] run_q
);

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (ev)
            EV_HOLD:    st_d.run = st_q.run;
            EV_ADVANCE: st_d.run = run_next;
            EV_CLEAR:   st_d.run = '0;
            EV_HIT:     st_d.run = '0;
            default:    st_d.run = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_q = st_q.run;

endmodule

// File: rtl/rcd_status.sv
module rcd_status
    import rcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rcd_event_e ev,
    input  logic       status_clr,
    output logic       seen_q,
    output logic       irq_q
);

    typedef struct packed {
        logic seen;
        logic irq;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = (ev == EV_HIT);
        // A detection in the same cycle as a clear keeps the flag set.
        st_d.seen = st_d.irq | (st_q.seen & ~status_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seen_q = st_q.seen;
    assign irq_q  = st_q.irq;

endmodule

// File: rtl/rcd_detector.sv
module rcd_detector
    import rcd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_vld,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] match_char,
    input  logic [CNT_W-1:0]  repeat_count,
    input  logic              detect_en,
    input  logic              rx_flush,
    input  logic              status_clr,
    output logic              pattern_seen,
    output logic              pattern_irq
);

    rcd_event_e       ev;
    logic [CNT_W-1:0] run_next;
    logic [CNT_W-1:0] run_q;

    rcd_match #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_match (
        .rx_vld       (rx_vld),
        .rx_byte      (rx_byte),
        .match_char   (match_char),
        .repeat_count (repeat_count),
        .detect_en    (detect_en),
        .rx_flush     (rx_flush),
        .run_q        (run_q),
        .ev           (ev),
        .run_next     (run_next)
    );

    rcd_run_ctr #(.CNT_W(CNT_W)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .run_next (run_next),
        .run_q    (run_q)
    );

    rcd_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .status_clr (status_clr),
        .seen_q     (pattern_seen),
        .irq_q      (pattern_irq)
    );

endmodule

// File: rtl/rcd_detector_chk.sv
module rcd_detector_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_vld,
    input logic [DATA_W-1:0] rx_byte,
    input logic [DATA_W-1:0] match_char,
    input logic              detect_en,
    input logic              rx_flush,
    input logic              status_clr,
    input logic [CNT_W-1:0]  run_q,
    input logic              pattern_seen,
    input logic              pattern_irq
);

    logic live;
    logic live_match;
    logic live_miss;

    always_comb begin
        live       = detect_en && !rx_flush && rx_vld;
        live_match = live && (rx_byte == match_char);
        live_miss  = live && (rx_byte != match_char);
    end

    AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == '0) || (run_q == $past(run_q)) || (run_q == $past(run_q) + CNT_W'(1))); // R2
    AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        live_miss |=> (run_q == '0)); // R3
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_seen && !status_clr) |=> pattern_seen); // R5
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> (!pattern_seen || pattern_irq)); // R5
    AST_HIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_irq |-> (run_q == '0)); // R6
    AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !detect_en |=> (run_q == '0 && !pattern_irq)); // R7
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (run_q == '0)); // R8
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_irq |-> pattern_seen); // R9
    AST_IRQ_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_irq |-> $past(live_match)); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_en && !rx_flush && !rx_vld) |=> $stable(run_q)); // R10

endmodule

bind rcd_detector rcd_detector_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_vld       (rx_vld),
    .rx_byte      (rx_byte),
    .match_char   (match_char),
    .detect_en    (detect_en),
    .rx_flush     (rx_flush),
    .status_clr   (status_clr),
    .run_q        (run_q),
    .pattern_seen (pattern_seen),
    .pattern_irq  (pattern_irq)
);

// File: tb/rcd_detector_test.sv
module rcd_detector_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_vld = 1'b0;
    logic [DATA_W-1:0] rx_byte = '0;
    logic [DATA_W-1:0] match_char = '0;
    logic [CNT_W-1:0]  repeat_count = '0;
    logic              detect_en = 1'b0;
    logic              rx_flush = 1'b0;
    logic              status_clr = 1'b0;
    logic              pattern_seen;
    logic              pattern_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench-side expectation derived from the requirements.
    int m_run  = 0;
    bit m_seen = 1'b0;
    bit m_irq  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcd_detector #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_vld       (rx_vld),
        .rx_byte      (rx_byte),
        .match_char   (match_char),
        .repeat_count (repeat_count),
        .detect_en    (detect_en),
        .rx_flush     (rx_flush),
        .status_clr   (status_clr),
        .pattern_seen (pattern_seen),
        .pattern_irq  (pattern_irq)
    );

    task automatic expect_bit(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    // Drive one cycle, advance the expectation, compare after the edge.
    task automatic step(input string req, input logic v, input logic [7:0] d,
                        input logic en, input logic fl, input logic clr);
        int tgt;
        @(negedge clk);
        rx_vld = v; rx_byte = d; detect_en = en; rx_flush = fl; status_clr = clr;
        @(posedge clk);
        tgt = (repeat_count == 0) ? 1 : int'(repeat_count);
        m_irq = 1'b0;
        if (fl || !en) m_run = 0;
        else if (v) begin
            if (d == match_char) begin
                if (m_run + 1 >= tgt) begin m_run = 0; m_irq = 1'b1; end
                else m_run = m_run + 1;
            end else m_run = 0;
        end
        m_seen = m_irq | (m_seen & ~clr);
        #(CLK_PERIOD/4);
        expect_bit(req, "pattern_seen", pattern_seen, m_seen);
        expect_bit(req, "pattern_irq", pattern_irq, m_irq);
        rx_vld = 1'b0; status_clr = 1'b0; rx_flush = 1'b0;
    endtask

    task automatic setup(input logic [7:0] ch, input logic [7:0] cnt);
        // Clear any partial run and the flag between scenarios.
        match_char = ch; repeat_count = cnt;
        step("R8", 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        logic [7:0] chars [3];
        chars[0] = 8'h00; chars[1] = 8'h5A; chars[2] = 8'hFF;

        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: reset state
        expect_bit("R1", "pattern_seen", pattern_seen, 1'b0);
        expect_bit("R1", "pattern_irq", pattern_irq, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R2: count 4 needs exactly four matches
        setup(8'h3C, 8'd4);
        repeat (3) step("R2", 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0);
        expect_bit("R2", "no flag before 4th", pattern_seen, 1'b0);
        step("R2", 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0);
        expect_bit("R2", "flag on 4th", pattern_seen, 1'b1);
        expect_bit("R9", "irq on 4th", pattern_irq, 1'b1);
        step("R9", 1'b0, 8'h3C, 1'b1, 1'b0, 1'b0);
        expect_bit("R9", "irq one cycle", pattern_irq, 1'b0);
        expect_bit("R5", "flag sticky", pattern_seen, 1'b1);
        step("R5", 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
        expect_bit("R5", "clear drops flag", pattern_seen, 1'b0);

        // R5: set wins over clear
        setup(8'h41, 8'd1);
        step("R5", 1'b1, 8'h41, 1'b1, 1'b0, 1'b1);
        expect_bit("R5", "set beats clear", pattern_seen, 1'b1);

        // R3: mismatch breaks run
        setup(8'h10, 8'd3);
        step("R3", 1'b1, 8'h10, 1'b1, 1'b0, 1'b0);
        step("R3", 1'b1, 8'h10, 1'b1, 1'b0, 1'b0);
        step("R3", 1'b1, 8'h11, 1'b1, 1'b0, 1'b0);
        step("R3", 1'b1, 8'h10, 1'b1, 1'b0, 1'b0);
        step("R3", 1'b1, 8'h10, 1'b1, 1'b0, 1'b0);
        expect_bit("R3", "no flag after broken run", pattern_seen, 1'b0);
        step("R3", 1'b1, 8'h10, 1'b1, 1'b0, 1'b0);
        expect_bit("R3", "flag after fresh run", pattern_seen, 1'b1);

        // R4: count zero acts as one
        setup(8'hA5, 8'd0);
        step("R4", 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0);
        expect_bit("R4", "single byte hits", pattern_irq, 1'b1);
        step("R4", 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0);
        expect_bit("R4", "every byte hits", pattern_irq, 1'b1);

        // R6: restart after detection
        setup(8'h7E, 8'd2);
        step("R6", 1'b1, 8'h7E, 1'b1, 1'b0, 1'b0);
        step("R6", 1'b1, 8'h7E, 1'b1, 1'b0, 1'b0);
        step("R6", 1'b1, 8'h7E, 1'b1, 1'b0, 1'b0);
        expect_bit("R6", "third byte no hit", pattern_irq, 1'b0);
        step("R6", 1'b1, 8'h7E, 1'b1, 1'b0, 1'b0);
        expect_bit("R6", "fourth byte hits", pattern_irq, 1'b1);

        // R7: disabled bytes ignored, partial run lost
        setup(8'h03, 8'd3);
        step("R7", 1'b1, 8'h03, 1'b1, 1'b0, 1'b0);
        step("R7", 1'b1, 8'h03, 1'b1, 1'b0, 1'b0);
        step("R7", 1'b1, 8'h03, 1'b0, 1'b0, 1'b0);
        expect_bit("R7", "disabled byte no hit", pattern_irq, 1'b0);
        step("R7", 1'b1, 8'h03, 1'b1, 1'b0, 1'b0);
        step("R7", 1'b1, 8'h03, 1'b1, 1'b0, 1'b0);
        expect_bit("R7", "run restarted", pattern_seen, 1'b0);
        step("R7", 1'b1, 8'h03, 1'b1, 1'b0, 1'b0);
        expect_bit("R7", "full run hits", pattern_irq, 1'b1);

        // R8: flush clears run and ignores its byte
        setup(8'hC3, 8'd3);
        step("R8", 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0);
        step("R8", 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0);
        step("R8", 1'b1, 8'hC3, 1'b1, 1'b1, 1'b0);
        expect_bit("R8", "flush byte no hit", pattern_irq, 1'b0);
        step("R8", 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0);
        step("R8", 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0);
        expect_bit("R8", "run restarted", pattern_seen, 1'b0);
        step("R8", 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0);
        expect_bit("R8", "full run hits", pattern_irq, 1'b1);

        // R10: idle cycles keep the run
        setup(8'h55, 8'd3);
        step("R10", 1'b1, 8'h55, 1'b1, 1'b0, 1'b0);
        step("R10", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        step("R10", 1'b1, 8'h55, 1'b1, 1'b0, 1'b0);
        step("R10", 1'b0, 8'h12, 1'b1, 1'b0, 1'b0);
        step("R10", 1'b1, 8'h55, 1'b1, 1'b0, 1'b0);
        expect_bit("R10", "hit across idles", pattern_irq, 1'b1);

        // Sweep: counts 0..6, three characters, mixed streams (R2 R3 R4 R9)
        lfsr = 8'h1D;
        for (int c = 0; c <= 6; c++) begin
            for (int k = 0; k < 3; k++) begin
                setup(chars[k], 8'(c));
                for (int s = 0; s < 80; s++) begin
                    int sel;
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    sel = int'(lfsr[3:0]);
                    if (sel < 9)
                        step("R2", 1'b1, chars[k], 1'b1, 1'b0, lfsr[7] & lfsr[6]);
                    else if (sel < 11)
                        step("R3", 1'b1, chars[k] ^ (lfsr | 8'h01), 1'b1, 1'b0, 1'b0);
                    else if (sel < 13)
                        step("R10", 1'b0, lfsr, 1'b1, 1'b0, 1'b0);
                    else if (sel == 13)
                        step("R7", 1'b1, chars[k], 1'b0, 1'b0, 1'b0);
                    else if (sel == 14)
                        step("R8", 1'b1, chars[k], 1'b1, 1'b1, 1'b0);
                    else
                        step("R5", 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule